// File: doc/BRIEF.md
# Dual-Mode 16-Bit Pulse Accumulator

This block counts activity on one external input pin into a 16-bit register. Software sets it up through a byte-wide control register and picks one of two modes. In event mode every edge of the chosen polarity adds one to the count. In gated mode the count advances once per 64 bus-clock cycles while the pin stays at the chosen level. When the gate closes, the trailing edge raises a flag. A count that rolls past its top value raises a second flag. Each flag has its own interrupt enable. The accumulator has its own enable and does not depend on any other timer logic.

The pin is synchronised by two flops, then fed to an edge detector. A four-state machine holds the gate history: ST_OFF (accumulator disabled), ST_EVENT (edge counting), ST_GATE_SHUT (gated mode, pin at the idle level) and ST_GATE_OPEN (gated mode, pin at the counting level). On every clock the machine moves to ST_OFF when the enable is clear. With the enable set it moves to ST_EVENT when the mode bit is clear. With the enable and mode bits both set it moves to ST_GATE_OPEN if the synchronised pin is at the counting level, and to ST_GATE_SHUT otherwise. The move from ST_GATE_OPEN to ST_GATE_SHUT is the trailing edge that sets the input flag. A free-running 6-bit prescaler supplies the divide-by-64 tick.

Software reaches four byte registers through a synchronous port. A write takes effect on the clock edge where it is presented. Reads are combinational from the address.

Top module: `pulse_accum`

## Requirements
- R1: Address 0 is the control register. Bit 6 is enable, bit 5 is mode (0 = event, 1 = gated), bit 4 is polarity, bits 3:2 are a stored clock-select field, bit 1 is the overflow interrupt enable and bit 0 is the input interrupt enable. Bit 7 always reads 0. All bits reset to 0, and the register can be written at any time.
- R2: Address 1 is status. Bit 0 is the input flag and bit 1 is the overflow flag; bits 7:2 read 0. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a flag is set by hardware in the same cycle that software clears it, the set wins. Both flags reset to 0.
- R3: Address 2 holds count bits 7:0 and address 3 holds count bits 15:8. A write loads that byte of the count. In a cycle where software writes the count, the hardware increment is dropped and no overflow is flagged. The count resets to 0.
- R4: The pin passes through two synchronising flops and one history flop. A pin change present before clock edge k advances the count on edge k+2, so the new value reads back after edge k+2.
- R5: In event mode, polarity 0 counts falling edges and polarity 1 counts rising edges. Each counted edge adds exactly one and sets the input flag. Edges of the other polarity have no effect.
- R6: In gated mode with polarity 0, the count advances by one on each prescaler tick while the synchronised pin is high. A high-to-low change of the synchronised pin sets the input flag.
- R7: In gated mode with polarity 1, the count advances by one on each prescaler tick while the synchronised pin is low. A low-to-high change of the synchronised pin sets the input flag.
- R8: An increment that takes the count from 0xFFFF to 0x0000 sets the overflow flag.
- R9: The overflow interrupt output is the overflow flag ANDed with control bit 1. The input interrupt output is the input flag ANDed with control bit 0.
- R10: While the enable bit is 0, the count holds its value, no flag is set, and the mode and polarity bits have no effect.
- R11: The prescaler counts from reset regardless of the enable bit. It gives a one-cycle tick every 64 clocks, so any 64 consecutive clocks contain exactly one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for addr |
| pin | input | 1 | Asynchronous accumulator input pin |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_in | output | 1 | Input-flag interrupt request |

## Verification
The event tests drive pulse trains with both polarity settings. Counting only the selected edge shows that the polarity bit really selects the edge and that each edge adds exactly one. A single edge timed against the clock pins down the three-register input latency. In gated mode the pin is held at the counting level for whole multiples of 64 cycles and then returned to the idle level. This separates tick-rate counting from edge counting, shows which trailing edge sets the flag for each polarity, and lets the bench measure the 64-cycle spacing between increments. Further runs with the enable cleared, a count preloaded near 0xFFFF, and status writes of 1 and 0 show holding, wrap detection and the clear rules. A behavioural model is compared on every clock and separates any deviation in timing from a wrong final value.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 2'd3;

    localparam int CB_EN    = 6;
    localparam int CB_MODE  = 5;
    localparam int CB_POL   = 4;
    localparam int CB_OVFIE = 1;
    localparam int CB_INIE  = 0;
    localparam int CTRL_W   = 7;

    localparam int SB_IN  = 0;
    localparam int SB_OVF = 1;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_SHUT = 2'd2,
        ST_GATE_OPEN = 2'd3
    } pa_state_e;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~hist_q;
    assign fall  = ~level & hist_q;
endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [PRE_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick = &div_q;
endmodule

// File: rtl/pa_fsm.sv
module pa_fsm
    import pa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic gated,
    input  logic pol,
    input  logic level,
    input  logic rise,
    input  logic fall,
    input  logic tick,
    output logic inc,
    output logic set_in
);
    pa_state_e state_q, state_d;
    logic      active;
    logic      hit;

    assign active = level ^ pol;
    assign hit    = pol ? rise : fall;

    always_comb begin
        if (!en)         state_d = ST_OFF;
        else if (!gated) state_d = ST_EVENT;
        else if (active) state_d = ST_GATE_OPEN;
        else             state_d = ST_GATE_SHUT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        inc    = 1'b0;
        set_in = 1'b0;
        if (en) begin
            if (!gated) begin
                inc    = hit;
                set_in = hit;
            end else begin
                inc = active & tick;
                unique case (state_q)
                    ST_GATE_OPEN: set_in = ~active;
                    ST_OFF, ST_EVENT, ST_GATE_SHUT: set_in = 1'b0;
                    default: set_in = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pa_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              pin,
    output logic              irq_ovf,
    output logic              irq_in
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  count_q;
    logic              in_flag_q, ovf_flag_q;
    logic              level, rise, fall, tick, inc, set_in;
    logic              wr_ctrl, wr_stat, wr_lo, wr_hi, wr_cnt, wrap;

    pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin),
        .level(level), .rise(rise), .fall(fall)
    );

    pa_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pa_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl_q[CB_EN]), .gated(ctrl_q[CB_MODE]), .pol(ctrl_q[CB_POL]),
        .level(level), .rise(rise), .fall(fall), .tick(tick),
        .inc(inc), .set_in(set_in)
    );

    assign wr_ctrl = wr_en && (addr == ADR_CTRL);
    assign wr_stat = wr_en && (addr == ADR_STATUS);
    assign wr_lo   = wr_en && (addr == ADR_CNT_LO);
    assign wr_hi   = wr_en && (addr == ADR_CNT_HI);
    assign wr_cnt  = wr_lo | wr_hi;
    assign wrap    = inc && !wr_cnt && (&count_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count_q <= '0;
        else if (wr_lo) count_q[BYTE_W-1:0] <= wr_data;
        else if (wr_hi) count_q[CNT_W-1:BYTE_W] <= wr_data;
        else if (inc)   count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_flag_q  <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            in_flag_q  <= set_in | (in_flag_q  & ~(wr_stat & wr_data[SB_IN]));
            ovf_flag_q <= wrap   | (ovf_flag_q & ~(wr_stat & wr_data[SB_OVF]));
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CTRL:   rd_data = {1'b0, ctrl_q};
            ADR_STATUS: rd_data = {6'b0, ovf_flag_q, in_flag_q};
            ADR_CNT_LO: rd_data = count_q[BYTE_W-1:0];
            ADR_CNT_HI: rd_data = count_q[CNT_W-1:BYTE_W];
            default:    rd_data = '0;
        endcase
    end

    assign irq_ovf = ovf_flag_q & ctrl_q[CB_OVFIE];
    assign irq_in  = in_flag_q  & ctrl_q[CB_INIE];
endmodule

// File: rtl/pa_checker.sv
module pa_checker
    import pa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [CTRL_W-1:0] ctrl,
    input logic [CNT_W-1:0]  count,
    input logic              in_flag,
    input logic              ovf_flag,
    input logic              tick,
    input logic              irq_in,
    input logic              irq_ovf
);
    logic wr_cnt, clr_in;
    assign wr_cnt = wr_en && (addr == ADR_CNT_LO || addr == ADR_CNT_HI);
    assign clr_in = wr_en && (addr == ADR_STATUS) && wr_data[SB_IN];

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_EN] && !wr_cnt) |=> $stable(count)); // R10
    AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_EN] && !in_flag) |=> !in_flag); // R10
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (count == $past(count) || count == $past(count) + 1'b1)); // R5
    AST_GATE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_EN] && ctrl[CB_MODE] && !wr_cnt && !tick) |=> $stable(count)); // R6
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && (&count)) |=> ((&count) || ovf_flag)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flag && !clr_in) |=> in_flag); // R2
    AST_IRQ_OVF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> (ctrl[CB_OVFIE] && ovf_flag)); // R9
    AST_IRQ_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |-> (ctrl[CB_INIE] && in_flag)); // R9
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11
endmodule

bind pulse_accum pa_checker u_pa_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctrl(ctrl_q), .count(count_q), .in_flag(in_flag_q), .ovf_flag(ovf_flag_q),
    .tick(tick), .irq_in(irq_in), .irq_ovf(irq_ovf)
);

// File: tb/pulse_accum_bench.sv
`timescale 1ns/1ps
module pulse_accum_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       pin = 1'b0;
    logic       irq_ovf, irq_in;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_accum u_pulse_accum (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pin(pin), .irq_ovf(irq_ovf), .irq_in(irq_in)
    );

    // behavioural reference model
    int m_ctrl, m_cnt, m_pre;
    bit m_inf, m_ovf, m_open;
    bit m_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_pre = 0;
            m_inf = 0; m_ovf = 0; m_open = 0;
            m_hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit cur, old, en, md, pol, tk, hit, act, inc, seti, wcnt;
            cur = m_hist[1]; old = m_hist[2];
            en = m_ctrl[6]; md = m_ctrl[5]; pol = m_ctrl[4];
            tk = (m_pre == 63);
            hit = pol ? (cur && !old) : (!cur && old);
            act = (cur != pol);
            inc  = en && (md ? (act && tk) : hit);
            seti = en && (md ? (m_open && !act) : hit);
            wcnt = wr_en && (addr == 2 || addr == 3);
            if (wr_en && addr == 1) begin
                if (wr_data[0]) m_inf = 0;
                if (wr_data[1]) m_ovf = 0;
            end
            if (seti) m_inf = 1;
            if (inc && !wcnt && m_cnt == 16'hFFFF) m_ovf = 1;
            if (wr_en && addr == 2)      m_cnt = (m_cnt & 16'hFF00) | wr_data;
            else if (wr_en && addr == 3) m_cnt = (m_cnt & 16'h00FF) | (int'(wr_data) << 8);
            else if (inc)                m_cnt = (m_cnt + 1) & 16'hFFFF;
            m_open = en && md && act;
            if (wr_en && addr == 0) m_ctrl = wr_data & 8'h7F;
            m_pre = (m_pre + 1) % 64;
            m_hist.push_front(pin);
            void'(m_hist.pop_back());
        end
    end

    function automatic int model_read(input int a);
        case (a)
            0: return m_ctrl;
            1: return (int'(m_ovf) << 1) | int'(m_inf);
            2: return m_cnt & 8'hFF;
            default: return (m_cnt >> 8) & 8'hFF;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            case (addr)
                2'd0: check("R1", rd_data, model_read(0), "ctrl vs model");
                2'd1: check("R2", rd_data, model_read(1), "status vs model");
                default: check("R3", rd_data, model_read(addr), "count byte vs model");
            endcase
            check("R9", {irq_ovf, irq_in},
                  {m_ovf && m_ctrl[1], m_inf && m_ctrl[0]}, "irq vs model");
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1'b1; addr = a[1:0]; wr_data = d[7:0];
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input int a, output int v);
        @(negedge clk); addr = a[1:0]; #2; v = rd_data;
    endtask

    task automatic rd_count(output int v);
        int lo, hi;
        peek(2, lo); peek(3, hi); v = (hi << 8) | lo;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin = ~pin; idle(3);
            @(negedge clk); pin = ~pin; idle(3);
        end
        idle(4);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v, v0, t0, t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // reset values
        peek(0, v); check("R1", v, 0, "ctrl reset");
        peek(1, v); check("R2", v, 0, "status reset");
        rd_count(v); check("R3", v, 0, "count reset");
        // control register read-back, bit 7 reads 0
        wr(0, 8'hFF); peek(0, v); check("R1", v, 8'h7F, "ctrl all ones");
        wr(0, 8'h0C); peek(0, v); check("R1", v, 8'h0C, "clock select field");
        // count load by bytes
        wr(2, 8'h34); wr(3, 8'h12); rd_count(v); check("R3", v, 16'h1234, "count load");
        // event mode, falling edges
        wr(2, 0); wr(3, 0); wr(0, 8'h40);
        pulses(4);
        rd_count(v); check("R5", v, 4, "falling edge count");
        peek(1, v); check("R5", v & 1, 1, "event sets input flag");
        wr(1, 8'h01); peek(1, v); check("R2", v, 0, "input flag clear");
        // latency of one edge: pin high now, drive falling edge before edge k
        @(negedge clk); pin = 1'b1; idle(6);
        rd_count(v0);
        @(negedge clk); addr = 2'd2; pin = 1'b0;
        @(negedge clk); #2; check("R4", rd_data, v0 & 8'hFF, "after edge k");
        @(negedge clk); #2; check("R4", rd_data, v0 & 8'hFF, "after edge k+1");
        @(negedge clk); #2; check("R4", rd_data, (v0 + 1) & 8'hFF, "after edge k+2");
        // event mode, rising edges
        wr(2, 0); wr(0, 8'h50);
        pulses(3);
        rd_count(v); check("R5", v, 3, "rising edge count");
        // disabled: mode/polarity ignored, count held
        wr(1, 8'h03); wr(0, 8'h30);
        pulses(3); idle(130);
        rd_count(v); check("R10", v, 3, "count held when off");
        peek(1, v); check("R10", v, 0, "no flags when off");
        // gated, polarity 0: high level counts
        wr(2, 0); wr(0, 8'h60);
        @(negedge clk); pin = 1'b1; idle(255);
        peek(1, v); check("R6", v & 1, 0, "no flag while gate open");
        @(negedge clk); pin = 1'b0; idle(6);
        rd_count(v); check("R6", v, 4, "gated high 256 cycles");
        peek(1, v); check("R6", v & 1, 1, "trailing fall sets flag");
        // prescaler spacing
        wr(1, 8'h01); wr(2, 0);
        @(negedge clk); pin = 1'b1; addr = 2'd2;
        t0 = -1; t1 = -1;
        for (int c = 0; c < 200 && t1 < 0; c++) begin
            @(negedge clk); #2;
            if (rd_data == 1 && t0 < 0) t0 = c;
            if (rd_data == 2 && t1 < 0) t1 = c;
        end
        check("R11", t1 - t0, 64, "tick spacing");
        @(negedge clk); pin = 1'b0; idle(6);
        // gated, polarity 1: low level counts
        wr(1, 8'h01); @(negedge clk); pin = 1'b1;
        wr(2, 0); wr(0, 8'h70); idle(4);
        @(negedge clk); pin = 1'b0; idle(127);
        @(negedge clk); pin = 1'b1; idle(6);
        rd_count(v); check("R7", v, 2, "gated low 128 cycles");
        peek(1, v); check("R7", v & 1, 1, "trailing rise sets flag");
        // overflow and interrupts
        wr(1, 8'h03); pin = 1'b0;
        wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h53);
        pulses(1);
        peek(1, v); check("R8", v, 1, "no wrap yet");
        pulses(1);
        rd_count(v); check("R8", v, 0, "wrap to zero");
        peek(1, v); check("R8", v, 3, "overflow flag");
        check("R9", {irq_ovf, irq_in}, 2'b11, "both irqs");
        wr(0, 8'h52); idle(1);
        check("R9", {irq_ovf, irq_in}, 2'b10, "input irq inhibited");
        wr(1, 8'h00); peek(1, v); check("R2", v, 3, "write 0 keeps flags");
        wr(1, 8'h02); peek(1, v); check("R2", v, 1, "clear overflow only");
        check("R9", {irq_ovf, irq_in}, 2'b00, "irqs after clear");
        idle(10);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule